// File: doc/BRIEF.md
# VPW Single-Byte In-Frame Response Transmitter

This block sits beside a variable-pulse-width bus receiver and answers a frame with a one-byte acknowledgement, such as the responder's node ID, inside the same frame. The host loads a byte and raises an arm request. A separate receiver reports the end-of-data (EOD) interval with a strobe and says whether the frame's CRC was good. If the block was armed before a good EOD, it marks the start of the response with an active normalization pulse and then sends the byte bit by bit, with no CRC. While it sends, it checks the bus for lost arbitration.

Several nodes may respond to the same frame. If another responder's normalization pulse is already on the bus when the block makes its decision, the block does not drive a pulse of its own. It waits for that pulse to end and starts its data bits from that point. Timing is measured in microsecond ticks from an external strobe: a short symbol is 64 ticks and a long one is 128 ticks. The bus level is 1 for active (dominant) and 0 for passive, on both `rx_line` and `tx_line`.

Top module: `vpw_ifr_tx`

## Requirements
- R1: After a synchronous reset, `tx_line` is 0 (passive), and `arm_pending`, `resp_done`, `lost_arb` and `aborted` are all 0.
- R2: An EOD strobe has no effect on the bus when the block is not armed. An arm request that arrives in the same cycle as the EOD strobe does not qualify that frame.
- R3: If the block is armed and the EOD strobe comes with `crc_ok` = 0, the block drives nothing, sets `aborted` and clears `arm_pending`.
- R4: If the block is armed and the EOD strobe comes with `crc_ok` = 1, and no other node is active on the bus in the next cycle, the block drives an active normalization pulse lasting exactly 64 ticks.
- R5: The byte follows with its MSB first. The first data symbol is passive and the bus level toggles on every symbol. A 0 bit is active for 128 ticks or passive for 64 ticks. A 1 bit is active for 64 ticks or passive for 128 ticks.
- R6: If `rx_line` is active in the cycle after a qualifying EOD, the block leaves `tx_line` passive for that whole pulse. The MSB's passive symbol begins when `rx_line` returns to passive, and the remaining bits follow R5.
- R7: At the end of every symbol, the block compares `rx_line` with `tx_line`. On a mismatch it releases the bus, sets `lost_arb`, clears `arm_pending`, stops, and never raises `resp_done`.
- R8: `resp_done` is high for exactly one clock after the last data symbol ends. In that same cycle `tx_line` is passive and `arm_pending` is cleared.
- R9: The byte is captured when the qualifying EOD occurs. A write to the data register while the response is being sent does not change the bits on the bus.
- R10: An arm request sets `arm_pending` and clears `lost_arb` and `aborted`. Otherwise both flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| rx_line | input | 1 | Synchronised bus level, 1 = active |
| eod_strobe | input | 1 | Receiver reports an EOD interval |
| crc_ok | input | 1 | CRC of the frame was good, valid with `eod_strobe` |
| data_in | input | 8 | Response byte from the host |
| data_wr | input | 1 | Load `data_in` into the data register |
| arm_req | input | 1 | Request a response to the next frame |
| tx_line | output | 1 | Bus drive, 1 = active |
| arm_pending | output | 1 | Response request outstanding |
| resp_done | output | 1 | One-clock pulse when the response completes |
| lost_arb | output | 1 | Sticky: arbitration was lost |
| aborted | output | 1 | Sticky: the request was dropped because of a CRC error |

## Verification
The assertions assume three things about the inputs: `us_tick` is a single-clock strobe, `eod_strobe` is a single-clock pulse, and `rx_line` is the wired-OR of this node's drive and the other nodes' drives, so it always reads active while `tx_line` is active. The bench builds `rx_line` in exactly that way, as a combinational OR of `tx_line` with a modelled foreign driver. It generates ticks from a fixed clock divider and asserts the foreign pulse only at falling clock edges. A second responder's normalization pulse and a dominating node are both modelled by that foreign driver, and it is raised only at the points those scenarios need.

// File: rtl/vpw_ifr_pkg.sv
package vpw_ifr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_NB_OWN,
        ST_NB_SHARED,
        ST_BITS
    } ifr_state_e;

endpackage

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             us_tick,
    input  logic [CNT_W-1:0] sym_len,
    output logic             sym_last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    assign sym_last = run && us_tick && (r_q.cnt == sym_len - 1'b1);

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
        end else if (us_tick) begin
            if (sym_last) r_d.cnt = '0;
            else          r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    // Every symbol is timed to its own length; the counter never runs past it (R5)
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (r_q.cnt < sym_len));

endmodule

// File: rtl/vpw_sym_shaper.sv
module vpw_sym_shaper #(
    parameter int unsigned T_SHORT = 64,
    parameter int unsigned T_LONG  = 128,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned POS_W   = 3
) (
    input  logic             nb_phase,
    input  logic [POS_W-1:0] pos,
    input  logic             bit_val,
    output logic             sym_level,
    output logic [CNT_W-1:0] sym_len
);

    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(T_SHORT);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(T_LONG);

    always_comb begin
        if (nb_phase) begin
            sym_level = 1'b1;
            sym_len   = LEN_S;
        end else begin
            sym_level = pos[0];
            if (pos[0]) sym_len = bit_val ? LEN_S : LEN_L;
            else        sym_len = bit_val ? LEN_L : LEN_S;
        end
    end

endmodule

// File: rtl/vpw_ifr_ctrl.sv
module vpw_ifr_ctrl
    import vpw_ifr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned POS_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              eod_strobe,
    input  logic              crc_ok,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              data_wr,
    input  logic              arm_req,
    input  logic              sym_last,
    input  logic              sym_level,
    output logic              nb_phase,
    output logic              sym_run,
    output logic [POS_W-1:0]  pos,
    output logic              bit_val,
    output logic              tx_line,
    output logic              arm_pending,
    output logic              resp_done,
    output logic              lost_arb,
    output logic              aborted
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

    typedef struct packed {
        ifr_state_e        st;
        logic              arm;
        logic [BYTE_W-1:0] hold;
        logic [BYTE_W-1:0] shreg;
        logic [POS_W-1:0]  pos;
        logic              tx;
        logic              done;
        logic              lost;
        logic              abrt;
    } ctrl_t;

    ctrl_t r_q, r_d;

    assign nb_phase    = (r_q.st == ST_NB_OWN);
    assign sym_run     = (r_q.st == ST_NB_OWN) || (r_q.st == ST_BITS);
    assign pos         = r_q.pos;
    assign bit_val     = r_q.shreg[BYTE_W-1];
    assign tx_line     = r_q.tx;
    assign arm_pending = r_q.arm;
    assign resp_done   = r_q.done;
    assign lost_arb    = r_q.lost;
    assign aborted     = r_q.abrt;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (data_wr) r_d.hold = data_in;
        if (arm_req) begin
            r_d.arm  = 1'b1;
            r_d.lost = 1'b0;
            r_d.abrt = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (eod_strobe && r_q.arm) begin
                    if (crc_ok) begin
                        r_d.st    = ST_DECIDE;
                        r_d.shreg = r_q.hold;
                    end else begin
                        r_d.abrt = 1'b1;
                        r_d.arm  = 1'b0;
                    end
                end
            end
            ST_DECIDE: begin
                if (rx_line) begin
                    r_d.st = ST_NB_SHARED;
                end else begin
                    r_d.st = ST_NB_OWN;
                    r_d.tx = 1'b1;
                end
            end
            ST_NB_SHARED: begin
                if (!rx_line) begin
                    r_d.st  = ST_BITS;
                    r_d.pos = '0;
                    r_d.tx  = 1'b0;
                end
            end
            ST_NB_OWN, ST_BITS: begin
                if (sym_last) begin
                    if (rx_line != r_q.tx) begin
                        r_d.st   = ST_IDLE;
                        r_d.tx   = 1'b0;
                        r_d.lost = 1'b1;
                        r_d.arm  = 1'b0;
                    end else if (r_q.st == ST_NB_OWN) begin
                        r_d.st  = ST_BITS;
                        r_d.pos = '0;
                        r_d.tx  = 1'b0;
                    end else if (r_q.pos == LAST_POS) begin
                        r_d.st   = ST_IDLE;
                        r_d.tx   = 1'b0;
                        r_d.done = 1'b1;
                        r_d.arm  = 1'b0;
                    end else begin
                        r_d.pos   = r_q.pos + 1'b1;
                        r_d.shreg = r_q.shreg << 1;
                        r_d.tx    = ~r_q.tx;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // Unarmed EOD leaves the bus passive (R2)
    assert_unarmed_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && eod_strobe && !r_q.arm) |=> !tx_line);

    // Bad CRC drops the request (R3)
    assert_abort_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && eod_strobe && r_q.arm && !crc_ok) |=> (aborted && !arm_pending && !tx_line));

    // Drive level agrees with the symbol shaper in every timed symbol (R5)
    assert_level_track_R5: assert property (@(posedge clk) disable iff (rst)
        sym_run |-> (tx_line == sym_level));

    // Another node's normalization pulse is never doubled (R6)
    assert_shared_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_NB_SHARED) |-> !tx_line);

    // Loss of arbitration releases the bus at once (R7)
    assert_lost_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_arb) |-> (!tx_line && !arm_pending && !resp_done));

    // Completion is a single-clock pulse with the bus released (R8)
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        resp_done |-> (!tx_line && !arm_pending));

endmodule

// File: rtl/vpw_ifr_tx.sv
module vpw_ifr_tx #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned T_SHORT = 64,
    parameter int unsigned T_LONG  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              rx_line,
    input  logic              eod_strobe,
    input  logic              crc_ok,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              data_wr,
    input  logic              arm_req,
    output logic              tx_line,
    output logic              arm_pending,
    output logic              resp_done,
    output logic              lost_arb,
    output logic              aborted
);

    localparam int unsigned CNT_W = $clog2(T_LONG + 1);
    localparam int unsigned POS_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic             nb_phase;
    logic             sym_run;
    logic [POS_W-1:0] pos;
    logic             bit_val;
    logic             sym_level;
    logic [CNT_W-1:0] sym_len;
    logic             sym_last;

    vpw_ifr_ctrl #(
        .BYTE_W (BYTE_W),
        .POS_W  (POS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rx_line     (rx_line),
        .eod_strobe  (eod_strobe),
        .crc_ok      (crc_ok),
        .data_in     (data_in),
        .data_wr     (data_wr),
        .arm_req     (arm_req),
        .sym_last    (sym_last),
        .sym_level   (sym_level),
        .nb_phase    (nb_phase),
        .sym_run     (sym_run),
        .pos         (pos),
        .bit_val     (bit_val),
        .tx_line     (tx_line),
        .arm_pending (arm_pending),
        .resp_done   (resp_done),
        .lost_arb    (lost_arb),
        .aborted     (aborted)
    );

    vpw_sym_shaper #(
        .T_SHORT (T_SHORT),
        .T_LONG  (T_LONG),
        .CNT_W   (CNT_W),
        .POS_W   (POS_W)
    ) u_shaper (
        .nb_phase  (nb_phase),
        .pos       (pos),
        .bit_val   (bit_val),
        .sym_level (sym_level),
        .sym_len   (sym_len)
    );

    vpw_sym_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (sym_run),
        .us_tick  (us_tick),
        .sym_len  (sym_len),
        .sym_last (sym_last)
    );

endmodule

// File: tb/vpw_ifr_tx_bench.sv
module vpw_ifr_tx_bench;

    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       eod_strobe = 1'b0;
    logic       crc_ok = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       data_wr = 1'b0;
    logic       arm_req = 1'b0;
    logic       other_act = 1'b0;
    logic       tx_line, arm_pending, resp_done, lost_arb, aborted;
    logic       rx_line;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    assign rx_line = tx_line | other_act;

    always #2.5 clk = ~clk;

    vpw_ifr_tx u_vpw_ifr_tx (
        .clk         (clk),
        .rst         (rst),
        .us_tick     (us_tick),
        .rx_line     (rx_line),
        .eod_strobe  (eod_strobe),
        .crc_ok      (crc_ok),
        .data_in     (data_in),
        .data_wr     (data_wr),
        .arm_req     (arm_req),
        .tx_line     (tx_line),
        .arm_pending (arm_pending),
        .resp_done   (resp_done),
        .lost_arb    (lost_arb),
        .aborted     (aborted)
    );

    // tick generator
    int div_q = 0;
    always @(negedge clk) begin
        div_q   <= (div_q == TDIV - 1) ? 0 : div_q + 1;
        us_tick <= (div_q == TDIV - 1);
    end

    // run-length monitor on tx_line, in ticks, plus done pulse tracking
    logic mon_clr = 1'b0;
    int   run_lvl [0:15];
    int   run_len [0:15];
    int   run_n = 0;
    logic cur_lvl = 1'b0;
    int   cur_len = 0;
    int   done_cnt = 0;
    int   done_run = 0;
    int   done_max = 0;

    always @(posedge clk) begin
        if (mon_clr) begin
            run_n    <= 0;
            cur_lvl  <= tx_line;
            cur_len  <= 0;
            done_cnt <= 0;
            done_run <= 0;
            done_max <= 0;
        end else begin
            if (tx_line != cur_lvl) begin
                if (run_n < 16) begin
                    run_lvl[run_n] <= int'(cur_lvl);
                    run_len[run_n] <= cur_len;
                end
                run_n   <= run_n + 1;
                cur_lvl <= tx_line;
                cur_len <= us_tick ? 1 : 0;
            end else if (us_tick) begin
                cur_len <= cur_len + 1;
            end
            if (resp_done) begin
                done_cnt <= done_cnt + 1;
                done_run <= done_run + 1;
                if (done_run + 1 > done_max) done_max <= done_run + 1;
            end else begin
                done_run <= 0;
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); data_in = b; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); arm_req = 1'b1;
        @(negedge clk); arm_req = 1'b0;
    endtask

    task automatic send_eod(input logic good, input logic foreign);
        @(negedge clk); eod_strobe = 1'b1; crc_ok = good;
        if (foreign) other_act = 1'b1;
        @(negedge clk); eod_strobe = 1'b0; crc_ok = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_cnt > 0 || lost_arb) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_len(input logic [7:0] b, input int i);
        logic bv;
        bv = b[7 - i];
        if (i % 2 == 1) return bv ? 64 : 128;
        return bv ? 128 : 64;
    endfunction

    task automatic check_bits(input logic [7:0] b, input int first_i, input int base, input string req);
        for (int i = first_i; i < 8; i++) begin
            int idx;
            idx = base + i;
            chk(run_lvl[idx] == (i % 2), req, run_lvl[idx], i % 2);
            chk(run_len[idx] == exp_len(b, i), req, run_len[idx], exp_len(b, i));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b0, "R1 tx", int'(tx_line), 0);
        chk(arm_pending == 1'b0 && resp_done == 1'b0, "R1 arm/done", int'({arm_pending, resp_done}), 0);
        chk(lost_arb == 1'b0 && aborted == 1'b0, "R1 flags", int'({lost_arb, aborted}), 0);
    endtask

    task automatic t_unarmed();
        clear_mon();
        send_eod(1'b1, 1'b0);
        repeat (300) @(negedge clk);
        chk(run_n == 0 && tx_line == 1'b0, "R2 unarmed eod", run_n, 0);
        clear_mon();
        @(negedge clk); arm_req = 1'b1; eod_strobe = 1'b1; crc_ok = 1'b1;
        @(negedge clk); arm_req = 1'b0; eod_strobe = 1'b0; crc_ok = 1'b0;
        repeat (300) @(negedge clk);
        chk(run_n == 0, "R2 late arm", run_n, 0);
        chk(arm_pending == 1'b1, "R10 arm set", int'(arm_pending), 1);
    endtask

    task automatic t_own(input logic [7:0] b, input bit rewrite);
        write_byte(b);
        arm();
        clear_mon();
        send_eod(1'b1, 1'b0);
        if (rewrite) begin
            repeat (50) @(negedge clk);
            write_byte(~b);
        end
        wait_end();
        chk(run_n == 10, "R4 symbol count", run_n, 10);
        chk(run_lvl[1] == 1 && run_len[1] == 64, "R4 normalization", run_len[1], 64);
        check_bits(b, 0, 2, rewrite ? "R9 captured byte" : "R5 data symbol");
        chk(done_cnt == 1 && done_max == 1, "R8 done pulse", done_max, 1);
        chk(arm_pending == 1'b0 && tx_line == 1'b0, "R8 arm cleared", int'({arm_pending, tx_line}), 0);
        chk(lost_arb == 1'b0, "R7 no loss", int'(lost_arb), 0);
    endtask

    task automatic t_shared(input logic [7:0] b);
        write_byte(b);
        arm();
        clear_mon();
        send_eod(1'b1, 1'b1);
        repeat (64 * TDIV) @(negedge clk);
        other_act = 1'b0;
        wait_end();
        chk(run_n == 8, "R6 symbol count", run_n, 8);
        check_bits(b, 1, 0, "R6 shared data symbol");
        chk(done_cnt == 1, "R6 done", done_cnt, 1);
    endtask

    task automatic t_lost();
        write_byte(8'h80);
        arm();
        clear_mon();
        send_eod(1'b1, 1'b0);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (run_n >= 2) break;
        end
        repeat (40) @(negedge clk);
        other_act = 1'b1;
        wait_end();
        chk(lost_arb == 1'b1, "R7 lost flag", int'(lost_arb), 1);
        chk(arm_pending == 1'b0 && done_cnt == 0, "R7 stop", done_cnt, 0);
        repeat (600) @(negedge clk);
        chk(tx_line == 1'b0 && run_n == 2, "R7 released", run_n, 2);
        other_act = 1'b0;
        repeat (20) @(negedge clk);
        chk(lost_arb == 1'b1, "R10 lost sticky", int'(lost_arb), 1);
        arm();
        chk(lost_arb == 1'b0 && arm_pending == 1'b1, "R10 lost cleared", int'(lost_arb), 0);
    endtask

    task automatic t_abort();
        clear_mon();
        send_eod(1'b0, 1'b0);
        @(negedge clk);
        chk(aborted == 1'b1 && arm_pending == 1'b0, "R3 aborted", int'(aborted), 1);
        repeat (300) @(negedge clk);
        chk(run_n == 0 && tx_line == 1'b0, "R3 no drive", run_n, 0);
        arm();
        chk(aborted == 1'b0, "R10 aborted cleared", int'(aborted), 0);
    endtask

    initial begin
        t_reset();
        t_unarmed();
        t_own(8'hA5, 1'b0);
        t_own(8'h00, 1'b0);
        t_own(8'hFF, 1'b0);
        t_own(8'h3C, 1'b1);
        t_shared(8'h96);
        t_lost();
        t_abort();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule